// File: doc/BRIEF.md
# Sampled-Bit Edge Time Extractor

This block turns a stream of 10-sample words into time-stamped edge records. Each word carries ten consecutive 1.2 ns samples of a discriminated hit signal, one word per 12 ns system tick, with bit 0 the earliest sample. The block looks at the previous word and the current word together as one 20-bit window, so a transition that lies on a word boundary is still found. An edge is accepted only when one sample of the old level is followed by at least N samples of the new level. N is programmable, so pulses shorter than N do not create an edge of their own.

For every accepted edge the block builds a 12-bit record from an edge-type bit, a wrapping 7-bit tick count and the 0..9 sample index of the first new-level sample. Records go into a 32-entry first-in first-out buffer that a consumer drains one entry per pop. An edge is reported in the word that carries the last sample of its N-sample run. When that run began in the previous word, the record carries the previous word's tick.

Top module: `edge_time_extractor`

## Requirements
- R1: After reset the buffer is empty (`hit_valid` = 0), `overflow` = 0, the tick count is 0 and the stored previous word is all zeros.
- R2: A leading edge is a 0 sample followed directly by N samples of 1; its record has type bit 11 = 0 and fine field [3:0] = index (0..9, bit 0 earliest) of the first 1 within its word.
- R3: A trailing edge is a 1 sample followed directly by N samples of 0; its record has type bit 11 = 1 and the fine field gives the index of the first 0.
- R4: A run of the new level shorter than N samples yields no edge of that type.
- R5: Each edge is reported once, in the word that holds the last sample of its N-sample run; if its first new-level sample lies in the previous word, the record's fine field is that sample's index in the previous word and its tick is the previous word's tick.
- R6: The tick count is the number of valid words since reset, modulo 128 (first word = 0); a cycle with `in_valid` = 0 advances no count, changes no stored word and writes no record.
- R7: Per word at most one leading and one trailing record are written, each the earliest of its type, and the leading record enters the buffer first.
- R8: A record is packed as {type [11], tick [10:4], fine [3:0]}; `hit_trailing` equals bit 11 of `hit_word`.
- R9: The buffer holds 32 records in arrival order; `hit_valid` is high while it is non-empty, `hit_word` shows the oldest record, and `hit_pop` with `hit_valid` high removes it.
- R10: A record that finds the buffer full (occupancy counted before a same-cycle pop) is dropped, and `overflow` then stays 1 until reset; with one free slot and two records, the leading one is kept.
- R11: `min_width` is used as N for 1..9; a value of 0 acts as 1 and values above 9 act as 9.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, one word per tick |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Qualifies `in_word` this cycle |
| in_word | input | 10 | Ten samples, bit 0 earliest |
| min_width | input | 4 | Minimum state length N |
| hit_pop | input | 1 | Remove the oldest record |
| hit_valid | output | 1 | Buffer holds at least one record |
| hit_word | output | 12 | Oldest record {type, tick, fine} |
| hit_trailing | output | 1 | Edge type of the oldest record, 1 = trailing |
| overflow | output | 1 | Sticky flag: a record was dropped |

## Verification
The hardest case to reach from the ports is a full buffer that meets a word with both a leading and a trailing edge while exactly one slot is free. Only that case shows whether the leading record is kept and the trailing one dropped. The stimulus gets there by stopping pops and feeding words with frequent level changes until the buffer overflows. The reference model counts occupancy itself and decides each drop. Boundary-straddling edges come from directed words whose runs start at bits 8 or 9, and from random run-length streams under N values that change during the run.

// File: rtl/ete_pkg.sv
package ete_pkg;
    localparam int SAMPLES  = 10;
    localparam int FINE_W   = 4;
    localparam int COARSE_W = 7;
    localparam int NW_W     = 4;
    localparam int WIN_W    = 2 * SAMPLES;
    localparam int POS_W    = $clog2(WIN_W);
    localparam int N_MAX    = SAMPLES - 1;
    localparam int HIT_W    = 1 + COARSE_W + FINE_W;

    typedef enum logic {
        EDGE_LEAD  = 1'b0,
        EDGE_TRAIL = 1'b1
    } edge_kind_e;

    typedef struct packed {
        edge_kind_e            kind;
        logic [COARSE_W-1:0]   coarse;
        logic [FINE_W-1:0]     fine;
    } hit_word_t;

    // Force the run length into the supported range 1..N_MAX
    function automatic logic [NW_W-1:0] clamp_width(input logic [NW_W-1:0] n);
        if (n == '0)
            return NW_W'(1);
        else if (n > NW_W'(N_MAX))
            return NW_W'(N_MAX);
        else
            return n;
    endfunction

    // Window position -> record; positions below SAMPLES belong to the previous word
    function automatic hit_word_t make_hit(input edge_kind_e k,
                                           input logic [POS_W-1:0] p,
                                           input logic [COARSE_W-1:0] t);
        hit_word_t h;
        h.kind = k;
        if (p >= POS_W'(SAMPLES)) begin
            h.fine   = FINE_W'(p - POS_W'(SAMPLES));
            h.coarse = t;
        end else begin
            h.fine   = FINE_W'(p);
            h.coarse = t - COARSE_W'(1);
        end
        return h;
    endfunction
endpackage

// File: rtl/ete_edge_scan.sv
module ete_edge_scan
    import ete_pkg::*;
#(
    parameter logic OLD_LEVEL = 1'b0
) (
    input  logic [WIN_W-1:0] window,
    input  logic [NW_W-1:0]  width,
    output logic             found,
    output logic [POS_W-1:0] first_pos
);
    logic             match_c;
    logic [POS_W-1:0] idx_c;

    // Candidate j ends its pattern on current-word bit j; scanning downward
    // leaves the earliest match in first_pos.
    always_comb begin
        found     = 1'b0;
        first_pos = '0;
        match_c   = 1'b0;
        idx_c     = '0;
        for (int j = SAMPLES - 1; j >= 0; j--) begin
            match_c = 1'b1;
            for (int i = 0; i <= N_MAX; i++) begin
                if (i <= int'(width)) begin
                    idx_c = POS_W'(j + SAMPLES - int'(width) + i);
                    if (window[idx_c] != ((i == 0) ? OLD_LEVEL : ~OLD_LEVEL))
                        match_c = 1'b0;
                end
            end
            if (match_c) begin
                found     = 1'b1;
                first_pos = POS_W'(j + SAMPLES + 1 - int'(width));
            end
        end
    end
endmodule

// File: rtl/ete_hit_fifo.sv
module ete_hit_fifo
    import ete_pkg::*;
#(
    parameter int DEPTH = 32
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      wr_a,
    input  hit_word_t data_a,
    input  logic      wr_b,
    input  hit_word_t data_b,
    input  logic      pop,
    output logic      out_valid,
    output hit_word_t out_data,
    output logic      ovf
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    hit_word_t       mem [DEPTH];
    logic [AW-1:0]   rptr, wptr;
    logic [CW-1:0]   count, free_c, nreq_c, nacc_c;
    hit_word_t       first_c, second_c;
    logic            pop_c;

    always_comb begin
        free_c   = CW'(DEPTH) - count;
        nreq_c   = CW'(wr_a) + CW'(wr_b);
        nacc_c   = (nreq_c > free_c) ? free_c : nreq_c;
        first_c  = wr_a ? data_a : data_b;
        second_c = data_b;
        pop_c    = pop && (count != '0);
    end

    always_ff @(posedge clk) begin
        if (nacc_c >= CW'(1)) mem[wptr] <= first_c;
        if (nacc_c == CW'(2)) mem[AW'(wptr + AW'(1))] <= second_c;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rptr  <= '0;
            wptr  <= '0;
            count <= '0;
            ovf   <= 1'b0;
        end else begin
            wptr  <= AW'(wptr + AW'(nacc_c));
            if (pop_c) rptr <= AW'(rptr + AW'(1));
            count <= count + nacc_c - CW'(pop_c);
            if (nreq_c > free_c) ovf <= 1'b1;
        end
    end

    assign out_valid = (count != '0);
    assign out_data  = mem[rptr];

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH));                                    // R9
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        ovf |=> ovf);                                            // R10
    AST_FULL_DROP: assert property (@(posedge clk) disable iff (rst)
        (count == CW'(DEPTH) && (wr_a || wr_b)) |=> ovf);        // R10
endmodule

// File: rtl/edge_time_extractor.sv
module edge_time_extractor
    import ete_pkg::*;
#(
    parameter int DEPTH = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic [SAMPLES-1:0]  in_word,
    input  logic [NW_W-1:0]     min_width,
    input  logic                hit_pop,
    output logic                hit_valid,
    output logic [HIT_W-1:0]    hit_word,
    output logic                hit_trailing,
    output logic                overflow
);
    logic [SAMPLES-1:0]  prev_q;
    logic [COARSE_W-1:0] tick_q;
    logic [WIN_W-1:0]    window;
    logic [NW_W-1:0]     n_eff;
    logic [1:0]          found;
    logic [POS_W-1:0]    pos [2];
    hit_word_t           hit_lead, hit_trail, head;

    assign window = {in_word, prev_q};
    assign n_eff  = clamp_width(min_width);

    for (genvar g = 0; g < 2; g++) begin : g_scan
        ete_edge_scan #(.OLD_LEVEL((g == 0) ? 1'b0 : 1'b1)) u_scan (
            .window    (window),
            .width     (n_eff),
            .found     (found[g]),
            .first_pos (pos[g])
        );
    end

    assign hit_lead  = make_hit(EDGE_LEAD,  pos[0], tick_q);
    assign hit_trail = make_hit(EDGE_TRAIL, pos[1], tick_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '0;
            tick_q <= '0;
        end else if (in_valid) begin
            prev_q <= in_word;
            tick_q <= tick_q + COARSE_W'(1);
        end
    end

    ete_hit_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk       (clk),
        .rst       (rst),
        .wr_a      (in_valid && found[0]),
        .data_a    (hit_lead),
        .wr_b      (in_valid && found[1]),
        .data_b    (hit_trail),
        .pop       (hit_pop),
        .out_valid (hit_valid),
        .out_data  (head),
        .ovf       (overflow)
    );

    assign hit_word     = head;
    assign hit_trailing = head.kind == EDGE_TRAIL;

    AST_TICK_ADV: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> tick_q == $past(tick_q) + COARSE_W'(1));    // R6
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(tick_q) && $stable(prev_q)));     // R6
    AST_NO_HIT_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!in_valid && !hit_valid) |=> !hit_valid);               // R6
    AST_LEAD_SHAPE: assert property (@(posedge clk) disable iff (rst)
        (in_valid && found[0]) |-> (!window[pos[0] - POS_W'(1)] && window[pos[0]]));  // R2
    AST_TRAIL_SHAPE: assert property (@(posedge clk) disable iff (rst)
        (in_valid && found[1]) |-> (window[pos[1] - POS_W'(1)] && !window[pos[1]]));  // R3
endmodule

// File: tb/edge_time_extractor_bench.sv
module edge_time_extractor_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [9:0]  in_word = '0;
    logic [3:0]  min_width = 4'd1;
    logic        hit_pop = 1'b0;
    logic        hit_valid;
    logic [11:0] hit_word;
    logic        hit_trailing;
    logic        overflow;

    always #2 clk = ~clk;

    edge_time_extractor u_edge_time_extractor (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_word(in_word),
        .min_width(min_width), .hit_pop(hit_pop), .hit_valid(hit_valid),
        .hit_word(hit_word), .hit_trailing(hit_trailing), .overflow(overflow)
    );

    int          n_chk = 0;
    int          n_fail = 0;
    string       cur_req = "R1";
    logic [9:0]  words [0:8191];
    int          wcount = 0;
    logic [11:0] q [$];
    logic        ovf_m = 1'b0;
    logic        level = 1'b0;
    int          cycles = 0;

    always @(posedge clk) cycles <= cycles + 1;

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", cur_req, what, act, exp);
        end
    endtask

    function automatic int eff_n(input logic [3:0] n);
        if (n == 0) return 1;
        if (n > 9) return 9;
        return int'(n);
    endfunction

    function automatic logic get_bit(input int g);
        if (g < 0) return 1'b0;
        return words[g / 10][g % 10];
    endfunction

    // Earliest global sample index whose run of n ends in word wi; -1 if none
    function automatic int find_edge(input int wi, input int n, input logic old_lvl);
        for (int f = 10 * wi - n + 1; f <= 10 * wi + 9 - n + 1; f++) begin
            logic ok;
            ok = (get_bit(f - 1) == old_lvl);
            for (int k = 0; k < n; k++)
                if (get_bit(f + k) == old_lvl) ok = 1'b0;
            if (ok) return f;
        end
        return -1;
    endfunction

    function automatic logic [11:0] rec(input logic kind, input int f);
        return {kind, 7'((f / 10) % 128), 4'(f % 10)};
    endfunction

    task automatic push_m(input logic [11:0] r);
        if (q.size() < 32) q.push_back(r);
        else ovf_m = 1'b1;
    endtask

    task automatic step(input logic v, input logic [9:0] w, input logic [3:0] n, input logic want_pop);
        logic p;
        @(negedge clk);
        chk("hit_valid", 32'(hit_valid), 32'(q.size() != 0));
        if (q.size() != 0) begin
            chk("hit_word", 32'(hit_word), 32'(q[0]));
            chk("hit_trailing", 32'(hit_trailing), 32'(q[0][11]));
        end
        chk("overflow", 32'(overflow), 32'(ovf_m));
        p = want_pop && (q.size() != 0);
        in_valid = v; in_word = w; min_width = n; hit_pop = p;
        @(posedge clk);
        if (v) begin
            int fl, ft, ne;
            ne = eff_n(n);
            words[wcount] = w;
            fl = find_edge(wcount, ne, 1'b0);
            ft = find_edge(wcount, ne, 1'b1);
            if (fl >= 0) push_m(rec(1'b0, fl));
            if (ft >= 0) push_m(rec(1'b1, ft));
            wcount++;
        end
        if (p) void'(q.pop_front());
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b0; hit_pop = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        q.delete(); ovf_m = 1'b0; wcount = 0;
    endtask

    function automatic logic [9:0] run_word(input int flip_pct);
        logic [9:0] w;
        for (int b = 0; b < 10; b++) begin
            if (int'($urandom % 100) < flip_pct) level = ~level;
            w[b] = level;
        end
        return w;
    endfunction

    initial begin : watchdog
        wait (cycles > 150000);
        n_fail++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd20240517));
        do_reset();
        cur_req = "R1";
        step(1'b0, 10'h000, 4'd3, 1'b0);
        chk("R1 reset hit_valid", 32'(hit_valid), 0);
        chk("R1 reset overflow", 32'(overflow), 0);

        cur_req = "R2"; // leading at bit 4, N=3
        step(1'b1, 10'b0000000000, 4'd3, 1'b0);
        step(1'b1, 10'b1111110000, 4'd3, 1'b0);
        cur_req = "R3"; // trailing at next word bit 0
        step(1'b1, 10'b1111111111, 4'd3, 1'b0);
        step(1'b1, 10'b0000000000, 4'd3, 1'b0);
        for (int i = 0; i < 4; i++) step(1'b0, 10'h2A5, 4'd3, 1'b1);

        cur_req = "R4"; // two-sample high glitch, N=4
        step(1'b1, 10'b0000110000, 4'd4, 1'b1);
        step(1'b1, 10'b0000000000, 4'd4, 1'b1);

        cur_req = "R5"; // run starts on bits 8,9 and continues
        step(1'b1, 10'b1100000000, 4'd5, 1'b1);
        step(1'b1, 10'b1111111111, 4'd5, 1'b1);
        step(1'b1, 10'b0000000001, 4'd5, 1'b1);
        step(1'b1, 10'b0000000000, 4'd5, 1'b1);

        cur_req = "R7"; // two of each type in one word, N=2
        step(1'b1, 10'b0011001100, 4'd2, 1'b0);
        step(1'b1, 10'b0000000000, 4'd2, 1'b1);
        for (int i = 0; i < 4; i++) step(1'b0, 10'h000, 4'd2, 1'b1);

        cur_req = "R6"; // invalid cycles carry noise
        step(1'b1, 10'b1110000000, 4'd2, 1'b1);
        for (int i = 0; i < 5; i++) step(1'b0, 10'($urandom), 4'd2, 1'b1);
        step(1'b1, 10'b1111111111, 4'd2, 1'b1);
        for (int i = 0; i < 3; i++) step(1'b0, 10'h000, 4'd2, 1'b1);

        cur_req = "R11"; // out-of-range widths
        for (int i = 0; i < 40; i++) step(1'b1, run_word(20), 4'd0, 1'b1);
        for (int i = 0; i < 40; i++) step(1'b1, run_word(8), 4'd15, 1'b1);

        cur_req = "R8"; // random streams, tick wraps
        begin
            logic [3:0] n;
            n = 4'd3;
            for (int i = 0; i < 3000; i++) begin
                if (i % 50 == 0) n = 4'(1 + $urandom % 9);
                if (i == 1500) cur_req = "R9";
                step(($urandom % 100) < 80, run_word(1 + $urandom % 30), n,
                     ($urandom % 100) < 60);
            end
        end
        for (int i = 0; i < 40; i++) step(1'b0, 10'h000, 4'd3, 1'b1);

        cur_req = "R10"; // no pops, busy stream until full
        for (int i = 0; i < 120; i++) step(1'b1, run_word(25), 4'd1, 1'b0);
        chk("R10 overflow expected set", 32'(ovf_m), 1);
        for (int i = 0; i < 40; i++) step(1'b0, 10'h000, 4'd1, 1'b1);
        for (int i = 0; i < 20; i++) step(1'b1, run_word(10), 4'd2, 1'b1);

        cur_req = "R1"; // reset clears sticky overflow
        do_reset();
        step(1'b0, 10'h000, 4'd2, 1'b0);
        chk("R1 overflow cleared", 32'(overflow), 0);
        chk("R1 buffer empty", 32'(hit_valid), 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule